// File: doc/BRIEF.md
# Write-Lock Unlock-Sequence Guard

This block sits in front of the page sequencer of a small byte-wide nonvolatile memory. It watches each write strobe (an 11-bit address and an 8-bit data byte) and recognizes two fixed in-band command sequences. A three-write sequence turns write protection on. A six-write sequence turns it off. While protection is on, ordinary writes and the whole-array erase are refused. The one exception is the page of writes that directly follows a completed enable sequence: those writes still go through.

The block drives three outputs:
- a lock flag;
- a per-strobe write-permit signal, which the page sequencer uses to decide whether to latch a byte;
- an erase-permit signal, which gates erase requests.

Writes that form part of a command sequence are never passed on to the array. A write that breaks a sequence part-way sends the detector back to idle, and that write is then judged as an ordinary write.

The lock flag stands in for a nonvolatile bit. Reset puts it in the delivered state, which is unprotected. A load input restores a stored value, for example after a power cycle.

Top module: `wr_lock_guard`

## Requirements
- R1: After reset the lock flag is 0, and an ordinary write (any write that is not a command step) gets wr_permit = 1 in the same cycle as its strobe.
- R2: The writes data AAh to address 555h, data 55h to 2AAh and data A0h to 555h, on consecutive strobes with idle cycles allowed between them, set lock_flag to 1 in the cycle after the third strobe.
- R3: The writes AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh and 20h to 555h, in that order, clear lock_flag to 0 in the cycle after the sixth strobe.
- R4: While lock_flag is 1 and no post-enable page window is open, every write strobe gets wr_permit = 0.
- R5: erase_permit equals erase_req AND NOT lock_flag.
- R6: Completing the enable sequence opens a page window. Ordinary writes in the window get wr_permit = 1 until a page_end pulse closes it. The window is also closed by the disable sequence and by a stored-value load.
- R7: A write that matches the next expected command step, including the A0h or 80h branch step, always gets wr_permit = 0, whatever the lock state.
- R8: A write that does not match the next expected step returns the detector to idle. That write gets wr_permit = NOT lock_flag OR window. A later step that would have continued the broken sequence is treated as an ordinary write.
- R9: A nv_load pulse copies nv_value into lock_flag, closes the window and drops any partial sequence. The load takes priority over a strobe in the same cycle.
- R10: lock_flag changes only through a completed enable sequence, a completed disable sequence or nv_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_load | input | 1 | Restore the lock flag from nv_value |
| nv_value | input | 1 | Stored lock value |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 11 | Write address |
| wr_data | input | 8 | Write data |
| page_end | input | 1 | Page sequencer has closed the current page |
| erase_req | input | 1 | Whole-array erase request |
| lock_flag | output | 1 | Write protection active |
| wr_permit | output | 1 | Current strobe may be committed to the array |
| erase_permit | output | 1 | Erase request may proceed |

## Verification
The hardest state to reach from the ports is the last step of the six-write disable sequence. Random writes almost never supply five exact address and data matches in a row, and the same applies to a sequence that breaks at its fourth or fifth step. The stimulus therefore weights addresses and data toward the command values and injects whole or truncated sequences at random points. Those points fall between page_end pulses and stored-value loads, so aborts, branch-step choices and window closures all occur while the flag is both set and clear.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
   localparam int NSTEP = 6;
   localparam int CW    = $clog2(NSTEP + 1);

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_ADV  = 2'd1,
      EV_SET  = 2'd2,
      EV_CLR  = 2'd3
   } ev_e;
endpackage

// File: rtl/wlg_step_match.sv
module wlg_step_match
   import wlg_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_A = 11'h555,
   parameter logic [ADDR_W-1:0] KEY_B = 11'h2AA,
   parameter logic [DATA_W-1:0] D_K1  = 8'hAA,
   parameter logic [DATA_W-1:0] D_K2  = 8'h55,
   parameter logic [DATA_W-1:0] D_SET = 8'hA0,
   parameter logic [DATA_W-1:0] D_BR  = 8'h80,
   parameter logic [DATA_W-1:0] D_CLR = 8'h20
) (
   input  logic              stb,
   input  logic [CW-1:0]     cnt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              cmd,
   output ev_e               ev
);
   logic [NSTEP-1:0] hit;
   logic             set_hit;

   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      localparam logic [ADDR_W-1:0] EA = (k == 1 || k == 4) ? KEY_B : KEY_A;
      localparam logic [DATA_W-1:0] ED = (k == 0 || k == 3) ? D_K1 :
                                         (k == 1 || k == 4) ? D_K2 :
                                         (k == 2)           ? D_BR : D_CLR;
      assign hit[k] = stb && (cnt == CW'(k)) && (addr == EA) && (data == ED);
   end

   assign set_hit = stb && (cnt == CW'(2)) && (addr == KEY_A) && (data == D_SET);
   assign cmd     = set_hit || (|hit);

   always_comb begin
      if (set_hit)            ev = EV_SET;
      else if (hit[NSTEP-1])  ev = EV_CLR;
      else if (|hit)          ev = EV_ADV;
      else                    ev = EV_NONE;
   end
endmodule

// File: rtl/wlg_state.sv
module wlg_state
   import wlg_pkg::*;
#(
   parameter bit INIT_LOCK = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          nv_load,
   input  logic          nv_value,
   input  logic          stb,
   input  ev_e           ev,
   input  logic          page_end,
   output logic [CW-1:0] cnt_q,
   output logic          lock_q,
   output logic          win_q
);
   logic [CW-1:0] cnt_d;
   logic          lock_d, win_d;

   always_comb begin
      cnt_d  = cnt_q;
      lock_d = lock_q;
      win_d  = win_q;
      if (nv_load) begin
         lock_d = nv_value;
         win_d  = 1'b0;
         cnt_d  = '0;
      end else begin
         if (stb) begin
            unique case (ev)
               EV_SET: begin lock_d = 1'b1; win_d = 1'b1; cnt_d = '0; end
               EV_CLR: begin lock_d = 1'b0; win_d = 1'b0; cnt_d = '0; end
               EV_ADV: cnt_d = cnt_q + CW'(1);
               default: cnt_d = '0;
            endcase
         end
         if (page_end && !(stb && ev == EV_SET)) win_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lock_q <= INIT_LOCK;
         win_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         lock_q <= lock_d;
         win_q  <= win_d;
      end
   end

   // R6
   win_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_q |-> lock_q);
   // R10
   lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_q) |-> $past(nv_load || (stb && (ev == EV_SET || ev == EV_CLR))));
   // R2
   set_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && ev == EV_SET && !nv_load) |=> (lock_q && win_q));
   // R3
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && ev == EV_CLR && !nv_load) |=> (!lock_q && !win_q));
   // R8
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && ev == EV_NONE && !nv_load) |=> (cnt_q == '0));
   // R9
   nv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_load |=> (lock_q == $past(nv_value) && !win_q && cnt_q == '0));
endmodule

// File: rtl/wr_lock_guard.sv
module wr_lock_guard
   import wlg_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_A = 11'h555,
   parameter logic [ADDR_W-1:0] KEY_B = 11'h2AA,
   parameter logic [DATA_W-1:0] D_K1  = 8'hAA,
   parameter logic [DATA_W-1:0] D_K2  = 8'h55,
   parameter logic [DATA_W-1:0] D_SET = 8'hA0,
   parameter logic [DATA_W-1:0] D_BR  = 8'h80,
   parameter logic [DATA_W-1:0] D_CLR = 8'h20,
   parameter bit INIT_LOCK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_load,
   input  logic              nv_value,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              page_end,
   input  logic              erase_req,
   output logic              lock_flag,
   output logic              wr_permit,
   output logic              erase_permit
);
   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("wr_lock_guard: ADDR_W and DATA_W must be at least 2");
   end
   if (KEY_A == KEY_B) begin : g_bad_key
      $error("wr_lock_guard: the two key addresses must differ");
   end
   if (D_SET == D_BR) begin : g_bad_branch
      $error("wr_lock_guard: branch data values must differ");
   end

   logic          cmd;
   ev_e           ev;
   logic [CW-1:0] cnt_q;
   logic          lock_q, win_q;

   wlg_step_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B),
      .D_K1(D_K1), .D_K2(D_K2), .D_SET(D_SET), .D_BR(D_BR), .D_CLR(D_CLR)
   ) u_match (
      .stb (wr_stb),
      .cnt (cnt_q),
      .addr(wr_addr),
      .data(wr_data),
      .cmd (cmd),
      .ev  (ev)
   );

   wlg_state #(.INIT_LOCK(INIT_LOCK)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .nv_load (nv_load),
      .nv_value(nv_value),
      .stb     (wr_stb),
      .ev      (ev),
      .page_end(page_end),
      .cnt_q   (cnt_q),
      .lock_q  (lock_q),
      .win_q   (win_q)
   );

   assign lock_flag    = lock_q;
   assign wr_permit    = wr_stb && !cmd && !nv_load && (!lock_q || win_q);
   assign erase_permit = erase_req && !lock_q;

   // R7
   cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd |-> !wr_permit);
   // R5
   erase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_flag |-> !erase_permit);
   // R4
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && lock_q && !win_q) |-> !wr_permit);
endmodule

// File: tb/tb_wr_lock_guard.sv
module tb_wr_lock_guard;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nv_load = 1'b0, nv_value = 1'b0;
   logic        wr_stb = 1'b0;
   logic [10:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        page_end = 1'b0, erase_req = 1'b0;
   logic        lock_flag, wr_permit, erase_permit;

   int checks = 0, fails = 0;
   int m_cnt = 0;
   bit m_lock = 0, m_win = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wr_lock_guard dut (
      .clk(clk), .rst_n(rst_n), .nv_load(nv_load), .nv_value(nv_value),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .page_end(page_end), .erase_req(erase_req),
      .lock_flag(lock_flag), .wr_permit(wr_permit), .erase_permit(erase_permit)
   );

   task automatic chk(input bit got, input bit exp, input string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit step_ok(int c, logic [10:0] a, logic [7:0] d);
      case (c)
         0: return a == 11'h555 && d == 8'hAA;
         1: return a == 11'h2AA && d == 8'h55;
         2: return a == 11'h555 && d == 8'h80;
         3: return a == 11'h555 && d == 8'hAA;
         4: return a == 11'h2AA && d == 8'h55;
         5: return a == 11'h555 && d == 8'h20;
         default: return 0;
      endcase
   endfunction

   function automatic bit is_set(int c, logic [10:0] a, logic [7:0] d);
      return c == 2 && a == 11'h555 && d == 8'hA0;
   endfunction

   task automatic finish_cycle(input string ltag);
      @(posedge clk);
      #1;
      wr_stb = 0; page_end = 0; nv_load = 0;
      chk(lock_flag, m_lock, ltag);
   endtask

   task automatic wr(input logic [10:0] a, input logic [7:0] d, input string ptag);
      bit cmd, exp_p, er;
      @(negedge clk);
      er = 1'($urandom % 2);
      wr_stb = 1; wr_addr = a; wr_data = d; erase_req = er;
      #1;
      cmd   = is_set(m_cnt, a, d) || step_ok(m_cnt, a, d);
      exp_p = !cmd && (!m_lock || m_win);
      chk(wr_permit, exp_p, cmd ? "R7" : ptag);
      chk(erase_permit, er && !m_lock, "R5");
      if (is_set(m_cnt, a, d)) begin
         m_lock = 1; m_win = 1; m_cnt = 0;
      end else if (step_ok(m_cnt, a, d)) begin
         if (m_cnt == 5) begin m_lock = 0; m_win = 0; m_cnt = 0; end
         else m_cnt++;
      end else m_cnt = 0;
      finish_cycle("R10");
   endtask

   task automatic pend();
      @(negedge clk);
      page_end = 1;
      m_win = 0;
      finish_cycle("R6");
   endtask

   task automatic nvload(input bit v);
      @(negedge clk);
      nv_load = 1; nv_value = v;
      m_lock = v; m_win = 0; m_cnt = 0;
      finish_cycle("R9");
   endtask

   task automatic seq_en();
      wr(11'h555, 8'hAA, "R2"); wr(11'h2AA, 8'h55, "R2"); wr(11'h555, 8'hA0, "R2");
   endtask

   task automatic seq_dis();
      wr(11'h555, 8'hAA, "R3"); wr(11'h2AA, 8'h55, "R3"); wr(11'h555, 8'h80, "R3");
      wr(11'h555, 8'hAA, "R3"); wr(11'h2AA, 8'h55, "R3"); wr(11'h555, 8'h20, "R3");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [10:0] ra;
      logic [7:0]  rd;
      void'($urandom(32'h5EED));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk(lock_flag, 0, "R1");
      @(negedge clk); erase_req = 1; #1;
      chk(erase_permit, 1, "R5");
      erase_req = 0;
      wr(11'h123, 8'h42, "R1");
      // R7 a command step is never committed, even unprotected
      wr(11'h555, 8'hAA, "R7");
      // R8 abort at third step, then a late A0h is ordinary
      wr(11'h2AA, 8'h55, "R7");
      wr(11'h100, 8'h12, "R8");
      wr(11'h555, 8'hA0, "R8");
      chk(lock_flag, 0, "R8");
      // R2 enable sequence
      seq_en();
      chk(lock_flag, 1, "R2");
      // R6 page window
      wr(11'h040, 8'h01, "R6");
      wr(11'h041, 8'h02, "R6");
      pend();
      wr(11'h042, 8'h03, "R4");
      @(negedge clk); erase_req = 1; #1;
      chk(erase_permit, 0, "R5");
      erase_req = 0;
      // R8 abort at step five of the disable sequence while locked
      wr(11'h555, 8'hAA, "R8"); wr(11'h2AA, 8'h55, "R8"); wr(11'h555, 8'h80, "R8");
      wr(11'h555, 8'hAA, "R8"); wr(11'h2AA, 8'h54, "R8");
      chk(lock_flag, 1, "R8");
      // R3 disable sequence
      seq_dis();
      chk(lock_flag, 0, "R3");
      // R9 stored value load
      nvload(1);
      chk(lock_flag, 1, "R9");
      wr(11'h200, 8'h77, "R4");
      nvload(0);
      wr(11'h555, 8'hAA, "R7"); wr(11'h2AA, 8'h55, "R7");
      nvload(0);
      wr(11'h555, 8'hA0, "R9");
      chk(lock_flag, 0, "R9");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 40;
         if (r < 2) seq_en();
         else if (r < 4) seq_dis();
         else if (r < 7) pend();
         else if (r == 7) nvload(1'($urandom % 2));
         else begin
            case ($urandom % 3)
               0: ra = 11'h555;
               1: ra = 11'h2AA;
               default: ra = 11'($urandom);
            endcase
            case ($urandom % 6)
               0: rd = 8'hAA;
               1: rd = 8'h55;
               2: rd = 8'hA0;
               3: rd = 8'h80;
               4: rd = 8'h20;
               default: rd = 8'($urandom);
            endcase
            wr(ra, rd, m_lock ? (m_win ? "R6" : "R4") : "R8");
         end
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule